// File: doc/BRIEF.md
# Monochrome Pixel Serializer

The block turns a stream of packed picture words into a one-bit-per-pixel monochrome image. It reads from a first-word-fall-through FIFO: the head word is already on the data input, and a single-cycle read-enable pulse consumes it. Three strobes from a raster timing generator drive it. The first marks pixels inside the visible window. The second fires on the last clock of a frame. The third fires on the clock before each visible line begins. The block stays idle until it sees the frame-end strobe. From then on it takes one word for every sixteen visible pixels and emits the bits lowest first, one bit on each visible clock.

Each emitted bit selects one of two fixed colours on three one-bit colour outputs. A set bit shows as red plus blue and a clear bit as green plus blue. A two-entry FIFO is enough, because the next word is taken on the same clock that shows the last bit of the current one. The visible line width must be a multiple of the word width, so a word never runs across the end of a line.

Top module: `mono_pixel_serializer`

## Requirements
- R1: The colour outputs always form one of two triples. For a data bit of 1 the outputs (red, green, blue) are (1,0,1). For a data bit of 0 they are (0,1,1). Blue is always 1 and green is always the inverse of red.
- R2: After reset the read enable is low and the outputs show the 0 colour (0,1,1).
- R3: Until the frame-end strobe first arrives, the read enable stays low, including during visible pixels, and the outputs stay at the 0 colour.
- R4: The first word is loaded on the first clock on which the line-start strobe is high, at or after the first frame-end strobe. A clock where both strobes are high counts. Bit 0 of that word appears on the next visible pixel.
- R5: After start, each clock with the visible flag high shows exactly one bit. The bits of a word appear in order from bit 0 to bit 15, and red equals the current bit.
- R6: The following word is loaded on the clock that shows bit 15 of the current word. Each load lasts one clock, so the read enable is never high on two clocks in a row.
- R7: On clocks with the visible flag low, no bit is used up. The next visible pixel continues with the bit after the last one shown.
- R8: The read enable is high only on a load clock with FIFO ready high. If ready is low on a load clock, that word slot shows sixteen 0 bits and the FIFO head is kept for the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_data_i | input | 16 | Head word of the FIFO |
| fifo_ready_i | input | 1 | FIFO holds a word |
| fifo_ren_o | output | 1 | One-clock pulse that consumes the head word |
| pix_active_i | input | 1 | Current pixel is inside the visible window |
| frame_last_i | input | 1 | Last clock of the frame |
| line_pre_i | input | 1 | Clock before a visible line begins |
| red_o | output | 1 | Red output |
| green_o | output | 1 | Green output |
| blue_o | output | 1 | Blue output |

## Verification
The case that is hardest to reach from the ports is an empty FIFO on a load clock. The block must then show a blank word and still keep the head word for the next load. The stimulus withholds FIFO ready for one whole visible line in the middle of the stream, so that at least one load falls inside that line, and then confirms that the later words come out in order. Start alignment is exercised by releasing reset part way through a frame, so visible pixels pass before the first frame-end strobe arrives.

// File: rtl/mono_ser_pkg.sv
package mono_ser_pkg;

   typedef struct packed {
      logic r;
      logic g;
      logic b;
   } rgb_t;

   localparam rgb_t COLOUR_SET = '{r: 1'b1, g: 1'b0, b: 1'b1};
   localparam rgb_t COLOUR_CLR = '{r: 1'b0, g: 1'b1, b: 1'b1};

endpackage

// File: rtl/mono_ser_ctrl.sv
module mono_ser_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic frame_last,
   input  logic line_pre,
   input  logic pix_active,
   input  logic last_bit,
   input  logic fifo_ready,
   output logic load,
   output logic shift_en,
   output logic fifo_ren
);

   logic armed_q;
   logic run_q;
   logic start;

   assign start    = !run_q && line_pre && (armed_q || frame_last);
   assign shift_en = run_q && pix_active;
   assign load     = start || (shift_en && last_bit);
   assign fifo_ren = load && fifo_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
         run_q   <= 1'b0;
      end else begin
         if (frame_last) armed_q <= 1'b1;
         if (start)      run_q   <= 1'b1;
      end
   end

   // R8
   ren_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
      fifo_ren |-> fifo_ready);

   // R6
   ren_single_chk: assert property (@(posedge clk) disable iff (rst)
      fifo_ren |=> !fifo_ren);

   // R3
   prestart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!armed_q && !frame_last) |-> !fifo_ren);

endmodule

// File: rtl/mono_ser_shift.sv
module mono_ser_shift #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              shift_en,
   input  logic              fill_valid,
   input  logic [WORD_W-1:0] word_in,
   output logic              bit_out,
   output logic              last_bit
);

   localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] sr_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         sr_q  <= fill_valid ? word_in : '0;
         cnt_q <= '0;
      end else if (shift_en) begin
         sr_q  <= sr_q >> 1;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign bit_out  = sr_q[0];
   assign last_bit = (cnt_q == CNT_LAST);

   // R8
   load_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (load && fill_valid) |=> (sr_q == $past(word_in)));

   // R8
   empty_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (load && !fill_valid) |=> (sr_q == '0));

   // R7
   blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!load && !shift_en) |=> ($stable(sr_q) && $stable(cnt_q)));

endmodule

// File: rtl/mono_ser_palette.sv
module mono_ser_palette
   import mono_ser_pkg::*;
#(
   parameter rgb_t ONE_COLOUR  = COLOUR_SET,
   parameter rgb_t ZERO_COLOUR = COLOUR_CLR
) (
   input  logic bit_in,
   output rgb_t colour
);

   assign colour = bit_in ? ONE_COLOUR : ZERO_COLOUR;

endmodule

// File: rtl/mono_pixel_serializer.sv
module mono_pixel_serializer
   import mono_ser_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] fifo_data_i,
   input  logic              fifo_ready_i,
   output logic              fifo_ren_o,
   input  logic              pix_active_i,
   input  logic              frame_last_i,
   input  logic              line_pre_i,
   output logic              red_o,
   output logic              green_o,
   output logic              blue_o
);

   generate
      if (WORD_W < 2 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_width
         $error("WORD_W must be a power of two of at least 2");
      end
   endgenerate

   logic load;
   logic shift_en;
   logic last_bit;
   logic bit_now;
   rgb_t colour;

   mono_ser_ctrl ctrl_i (
      .clk        (clk),
      .rst        (rst),
      .frame_last (frame_last_i),
      .line_pre   (line_pre_i),
      .pix_active (pix_active_i),
      .last_bit   (last_bit),
      .fifo_ready (fifo_ready_i),
      .load       (load),
      .shift_en   (shift_en),
      .fifo_ren   (fifo_ren_o)
   );

   mono_ser_shift #(.WORD_W(WORD_W)) shift_i (
      .clk        (clk),
      .rst        (rst),
      .load       (load),
      .shift_en   (shift_en),
      .fill_valid (fifo_ready_i),
      .word_in    (fifo_data_i),
      .bit_out    (bit_now),
      .last_bit   (last_bit)
   );

   mono_ser_palette palette_i (
      .bit_in (bit_now),
      .colour (colour)
   );

   assign red_o   = colour.r;
   assign green_o = colour.g;
   assign blue_o  = colour.b;

   // R1
   colour_legal_chk: assert property (@(posedge clk) disable iff (rst)
      (blue_o && (green_o != red_o)));

endmodule

// File: tb/mono_pixel_serializer_tb.sv
module mono_pixel_serializer_tb_top;

   localparam int H_TOT = 40;
   localparam int H_ACT = 32;
   localparam int V_TOT = 5;
   localparam int V_ACT = 3;
   localparam int QLEN  = 40;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] fifo_data = '0;
   logic        fifo_ready = 1'b0;
   logic        fifo_ren;
   logic        pix_active = 1'b0;
   logic        frame_last = 1'b0;
   logic        line_pre = 1'b0;
   logic        red, green, blue;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   mono_pixel_serializer dut_i (
      .clk          (clk),
      .rst          (rst),
      .fifo_data_i  (fifo_data),
      .fifo_ready_i (fifo_ready),
      .fifo_ren_o   (fifo_ren),
      .pix_active_i (pix_active),
      .frame_last_i (frame_last),
      .line_pre_i   (line_pre),
      .red_o        (red),
      .green_o      (green),
      .blue_o       (blue)
   );

   logic [15:0] q [0:QLEN-1];

   task automatic check(input logic ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int head = 0;
      logic [15:0] cur = '0;
      int bitn = 0;
      logic armed = 1'b0;
      logic running = 1'b0;
      int starved = 0;
      int prestart_active = 0;
      int x = 0;
      int y = 2;
      int frame = 0;
      logic starve;
      logic exp_load, exp_ren, exp_red;

      for (int k = 0; k < QLEN; k++) q[k] = 16'(k * 40503 + 1);
      q[1] = 16'hFFFF;
      q[2] = 16'h0000;

      repeat (3) @(negedge clk);
      // R2 reset state
      #1;
      check(fifo_ren == 1'b0, "R2 ren after reset", fifo_ren, 0);
      check({red, green, blue} == 3'b011, "R2 colour after reset", {red, green, blue}, 3);
      @(negedge clk);
      rst = 1'b0;

      for (int cyc = 0; cyc < 5 * H_TOT * V_TOT; cyc++) begin
         pix_active = (x < H_ACT) && (y < V_ACT);
         frame_last = (x == H_TOT - 1) && (y == V_TOT - 1);
         line_pre   = (x == H_TOT - 1) && ((y == V_TOT - 1) || (y < V_ACT - 1));
         starve     = (frame == 2) && (y == 1);
         fifo_ready = (head < QLEN) && !starve;
         fifo_data  = (head < QLEN) ? q[head] : 16'h0;
         #1;
         exp_load = (!running && line_pre && (armed || frame_last)) ||
                    (running && pix_active && bitn == 15);
         exp_ren  = exp_load && fifo_ready;
         exp_red  = cur[bitn];
         // R1 colour mapping
         check(blue && (green == !red), "R1 colour triple", {red, green, blue}, exp_red ? 5 : 3);
         // R5 / R7 bit order and hold
         check(red == exp_red, running ? "R5 R7 pixel bit" : "R3 idle colour", red, exp_red);
         // R6 / R8 load timing and gating
         check(fifo_ren == exp_ren, "R6 R8 read enable", fifo_ren, exp_ren);
         if (!armed && !frame_last) begin
            // R3 no read before frame end
            check(fifo_ren == 1'b0, "R3 no read before start", fifo_ren, 0);
            if (pix_active) prestart_active++;
         end
         // model update for this clock edge
         if (frame_last) armed = 1'b1;
         if (exp_load) begin
            if (!running) begin
               // R4 first load on first line-start strobe after frame end
               check(fifo_ren == fifo_ready, "R4 first load", fifo_ren, fifo_ready);
            end
            running = 1'b1;
            if (fifo_ready) begin
               cur = q[head];
               head++;
            end else begin
               cur = '0;
               starved++;
            end
            bitn = 0;
         end else if (running && pix_active) begin
            bitn++;
         end
         x++;
         if (x == H_TOT) begin
            x = 0;
            y++;
            if (y == V_TOT) begin
               y = 0;
               frame++;
            end
         end
         @(negedge clk);
      end

      // R3 stimulus really had visible pixels before start
      check(prestart_active > 0, "R3 prestart pixels seen", prestart_active, H_ACT);
      // R8 an empty-FIFO load was exercised
      check(starved > 0, "R8 starved load exercised", starved, 1);
      // R6 words were consumed
      check(head > 10, "R6 words consumed", head, 11);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule